// File: doc/BRIEF.md
# Script Load/Store Execution Unit

This unit carries out one two-word load/store command handed to it by a script processor. The first word holds the opcode, the direction, a flag that selects relative addressing, a flag that suppresses the flush, a register index and a byte count. The second word holds either a full 32-bit bus address or a signed 24-bit offset. The offset is added to a data-structure base register. The unit then moves one to four bytes between an internal register file and the bus, one byte per bus handshake. The bus access goes to memory space or I/O space, as a mode input selects for the direction in use.

Commands arrive on a valid/ready stream. `cmd_ready` is high only while the unit is idle. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. While a transfer runs, `cmd_ready` stays low and the producer must hold its command. The bus side is a request/acknowledge master. `bus_req` and all bus fields stay stable until the cycle that `bus_ack` is sampled high, and each such cycle completes one byte. Completion gives a one-cycle `done` pulse. When the command was a store that asked for a flush, `flush_req` pulses in the same cycle. A malformed command gives an `illegal` pulse and no bus access.

Top module: `lsx_unit`

## Requirements
- R1: A command is recognised only when word0[31:29] is 3'b111. Otherwise the cycle after acceptance shows `illegal`=1 and `done`=0, and no bus request is made.
- R2: When word0[28] is 0, the first bus address equals word1 unchanged.
- R3: When word0[28] is 1, the first bus address is `base_addr` plus the sign-extended value of word1[23:0]. word1[31:24] is ignored.
- R4: The byte count is word0[2:0]. A count of 0, or a count from 5 to 7, gives `illegal` in the cycle after acceptance and no bus request.
- R5: When word0[24] is 1 (load), `bus_write` is 0. On every acknowledged beat, `bus_rdata` is written to the register at `reg_addr`, with `reg_we`=1 in that cycle. The register index starts at word0[22:16].
- R6: When word0[24] is 0 (store), `bus_write` is 1 and `bus_wdata` carries the register byte read at `reg_addr`.
- R7: `bus_io` equals `src_io` for a load and `dst_io` for a store, sampled when the command is accepted.
- R8: Bytes move one per acknowledged beat. The bus address and the register index each rise by one after every beat. Request fields stay stable while `bus_ack` is low.
- R9: `done` is a one-cycle pulse in the cycle after the last acknowledged beat.
- R10: A store with word0[25]=0 pulses `flush_req` together with `done`. A store with word0[25]=1 gives no flush. For a load, word0[25] is ignored and no flush is made.
- R11: `cmd_ready` is 1 exactly when no transfer is in progress. After reset it is 1, and `bus_req`, `done`, `illegal` and `flush_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word pair is valid |
| cmd_ready | output | 1 | Unit idle, able to take a command |
| cmd_word0 | input | 32 | First command word |
| cmd_word1 | input | 32 | Second command word (address or offset) |
| base_addr | input | 32 | Data-structure base register |
| src_io | input | 1 | Load source is I/O space when 1 |
| dst_io | input | 1 | Store destination is I/O space when 1 |
| bus_req | output | 1 | Bus beat requested |
| bus_ack | input | 1 | Bus beat accepted |
| bus_addr | output | 32 | Byte address of current beat |
| bus_write | output | 1 | 1 = write (store), 0 = read (load) |
| bus_io | output | 1 | 1 = I/O command, 0 = memory command |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte |
| reg_addr | output | 7 | Register file index |
| reg_rdata | input | 8 | Register file read byte |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write byte |
| done | output | 1 | Command completed (pulse) |
| flush_req | output | 1 | Prefetch flush request (pulse) |
| illegal | output | 1 | Malformed command (pulse) |

## Verification
The checker watches properties that must hold in every cycle. Bus fields must hold while a beat waits for acknowledge. The address must step by one per beat. A flush must always come with a done. An illegal pulse must never overlap a request. The ready output must be low during a transfer, and register writes may occur only on acknowledged read beats. Other behaviour can only be shown by the bench's scenarios. These include the exact addresses from absolute and relative forms, with a negative offset and a high byte that must be ignored. They also include the choice of I/O space per direction, the bytes that reach the registers, and whether a flush follows each mix of direction and no-flush bit.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  localparam int RA_W  = 7;
  localparam int BC_W  = 3;
  localparam int OFS_W = 24;

  typedef enum logic {ST_IDLE, ST_XFER} lsx_state_e;

  typedef struct packed {
    logic            ok;
    logic            rel;
    logic            nf;
    logic            ld;
    logic [RA_W-1:0] ra;
    logic [BC_W-1:0] bc;
  } lsx_cmd_t;
endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
  import lsx_pkg::*;
#(
  parameter int MAX_BEATS = 4
) (
  input  logic [31:0] word0,
  output lsx_cmd_t    cmd
);
  logic opcode_hit;
  logic count_ok;

  always_comb begin
    opcode_hit = (word0[31:29] == 3'b111);
    count_ok   = (word0[BC_W-1:0] != '0) && (int'(word0[BC_W-1:0]) <= MAX_BEATS);
    cmd.ok  = opcode_hit && count_ok;
    cmd.rel = word0[28];
    cmd.nf  = word0[25];
    cmd.ld  = word0[24];
    cmd.ra  = word0[22:16];
    cmd.bc  = word0[BC_W-1:0];
  end
endmodule

// File: rtl/lsx_agen.sv
module lsx_agen
  import lsx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              rel,
  input  logic [31:0]       word1,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] ofs_ext;

  generate
    if (ADDR_W > OFS_W) begin : g_ext
      assign ofs_ext = {{(ADDR_W-OFS_W){word1[OFS_W-1]}}, word1[OFS_W-1:0]};
    end else begin : g_trunc
      assign ofs_ext = word1[ADDR_W-1:0];
    end
  endgenerate

  assign addr = rel ? (base + ofs_ext) : word1[ADDR_W-1:0];
endmodule

// File: rtl/lsx_seq.sv
module lsx_seq
  import lsx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  lsx_cmd_t          cmd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              src_io,
  input  logic              dst_io,
  input  logic              bus_ack,
  output logic              idle,
  output logic              xfer,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [RA_W-1:0]   cur_reg,
  output logic              is_load,
  output logic              io_space,
  output logic              done,
  output logic              flush_req,
  output logic              illegal
);
  lsx_state_e      state;
  logic [BC_W-1:0] left;
  logic            flush_en;
  logic            beat;

  assign idle = (state == ST_IDLE);
  assign xfer = (state == ST_XFER);
  assign beat = xfer && bus_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      left      <= '0;
      cur_addr  <= '0;
      cur_reg   <= '0;
      is_load   <= 1'b0;
      io_space  <= 1'b0;
      flush_en  <= 1'b0;
      done      <= 1'b0;
      flush_req <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done      <= 1'b0;
      flush_req <= 1'b0;
      illegal   <= 1'b0;
      if (idle && take) begin
        if (cmd.ok) begin
          state    <= ST_XFER;
          left     <= cmd.bc;
          cur_addr <= start_addr;
          cur_reg  <= cmd.ra;
          is_load  <= cmd.ld;
          io_space <= cmd.ld ? src_io : dst_io;
          flush_en <= !cmd.ld && !cmd.nf;
        end else begin
          illegal <= 1'b1;
        end
      end else if (beat) begin
        cur_addr <= cur_addr + 1'b1;
        cur_reg  <= cur_reg + 1'b1;
        left     <= left - 1'b1;
        if (left == BC_W'(1)) begin
          state     <= ST_IDLE;
          done      <= 1'b1;
          flush_req <= flush_en;
        end
      end
    end
  end
endmodule

// File: rtl/lsx_unit.sv
module lsx_unit
  import lsx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 8,
  parameter int MAX_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_word0,
  input  logic [31:0]       cmd_word1,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              src_io,
  input  logic              dst_io,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic              bus_io,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              done,
  output logic              flush_req,
  output logic              illegal
);
  lsx_cmd_t          cmd;
  logic [ADDR_W-1:0] start_addr;
  logic              idle;
  logic              xfer;
  logic              is_load;

  lsx_decode #(.MAX_BEATS(MAX_BEATS)) u_dec (
    .word0 (cmd_word0),
    .cmd   (cmd)
  );

  lsx_agen #(.ADDR_W(ADDR_W)) u_agen (
    .rel   (cmd.rel),
    .word1 (cmd_word1),
    .base  (base_addr),
    .addr  (start_addr)
  );

  lsx_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (cmd_valid),
    .cmd        (cmd),
    .start_addr (start_addr),
    .src_io     (src_io),
    .dst_io     (dst_io),
    .bus_ack    (bus_ack),
    .idle       (idle),
    .xfer       (xfer),
    .cur_addr   (bus_addr),
    .cur_reg    (reg_addr),
    .is_load    (is_load),
    .io_space   (bus_io),
    .done       (done),
    .flush_req  (flush_req),
    .illegal    (illegal)
  );

  assign cmd_ready = idle;
  assign bus_req   = xfer;
  assign bus_write = !is_load;
  assign bus_wdata = reg_rdata;
  assign reg_we    = xfer && bus_ack && is_load;
  assign reg_wdata = bus_rdata;
endmodule

// File: rtl/lsx_unit_checker.sv
module lsx_unit_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic              bus_io,
  input logic [6:0]        reg_addr,
  input logic              reg_we,
  input logic              done,
  input logic              flush_req,
  input logic              illegal
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_write) && $stable(bus_io) && $stable(reg_addr)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req || (bus_addr == $past(bus_addr) + 1'b1)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_req && bus_ack)); // R9
  AST_FLUSH_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> done); // R10
  AST_ILLEGAL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !bus_req && !done); // R4
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cmd_ready); // R11
  AST_REGWR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> bus_req && bus_ack && !bus_write); // R5
endmodule

bind lsx_unit lsx_unit_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_write (bus_write),
  .bus_io    (bus_io),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .done      (done),
  .flush_req (flush_req),
  .illegal   (illegal)
);

// File: tb/lsx_unit_test.sv
module lsx_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word0 = '0;
  logic [31:0] cmd_word1 = '0;
  logic [31:0] base_addr = '0;
  logic        src_io = 1'b0;
  logic        dst_io = 1'b0;
  logic        bus_req;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic        bus_io;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic [6:0]  reg_addr;
  logic [7:0]  reg_rdata;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic        done;
  logic        flush_req;
  logic        illegal;

  int checks = 0;
  int failures = 0;
  logic [7:0] regs [128];

  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic        io;
    logic [7:0]  d;
    logic [6:0]  r;
  } beat_t;
  typedef struct packed { logic dn; logic fl; logic il; } comp_t;
  beat_t beat_q[$];
  comp_t comp_q[$];

  always #10 clk = ~clk;

  lsx_unit uut (.*);

  assign reg_rdata = regs[reg_addr];
  always @(posedge clk) if (reg_we) regs[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w0(bit [2:0] op, bit rel, bit nf, bit ld,
                                        bit [6:0] ra, bit [2:0] bc);
    return {op, rel, 2'b00, nf, ld, 1'b0, ra, 13'b0, bc};
  endfunction

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // Responder and monitor
  int gap = 0;
  int waitc = 0;
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (waitc >= gap) begin
        beat_t e;
        if (beat_q.size() == 0) begin
          chk(0, "R8", "unexpected beat", bus_addr, 0);
        end else begin
          e = beat_q.pop_front();
          chk(bus_addr == e.a, "R8", "beat address", bus_addr, e.a);
          chk(bus_write == e.w, e.w ? "R6" : "R5", "direction", bus_write, e.w);
          chk(bus_io == e.io, "R7", "space", bus_io, e.io);
          chk(reg_addr == e.r, "R8", "register index", reg_addr, e.r);
          chk(!cmd_ready, "R11", "ready during transfer", cmd_ready, 0);
          if (e.w) chk(bus_wdata == e.d, "R6", "store byte", bus_wdata, e.d);
        end
        bus_rdata = mem_byte(bus_addr);
        bus_ack = 1'b1;
        waitc = 0;
        gap = (gap + 1) % 3;
      end else begin
        waitc++;
      end
    end
    if (done || illegal || flush_req) begin
      comp_t c;
      if (comp_q.size() == 0) begin
        chk(0, "R9", "unexpected completion", {done, flush_req, illegal}, 0);
      end else begin
        c = comp_q.pop_front();
        chk(done == c.dn, c.il ? "R4" : "R9", "done", done, c.dn);
        chk(flush_req == c.fl, "R10", "flush", flush_req, c.fl);
        chk(illegal == c.il, c.il ? "R1" : "R4", "illegal", illegal, c.il);
      end
    end
  end

  task automatic issue(input logic [31:0] w0, input logic [31:0] w1,
                       input logic [31:0] exp_addr, input bit legal,
                       input bit exp_flush, input bit io, input string req);
    bit ld = w0[24];
    logic [6:0] ra = w0[22:16];
    int n = w0[2:0];
    logic [7:0] exp_d [4];
    if (legal) begin
      for (int i = 0; i < n; i++) begin
        beat_t b;
        b.a = exp_addr + i;
        b.w = !ld;
        b.io = io;
        b.r = ra + 7'(i);
        b.d = ld ? mem_byte(b.a) : regs[b.r];
        exp_d[i] = b.d;
        beat_q.push_back(b);
      end
      comp_q.push_back('{dn: 1'b1, fl: exp_flush, il: 1'b0});
    end else begin
      comp_q.push_back('{dn: 1'b0, fl: 1'b0, il: 1'b1});
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_word0 = w0;
    cmd_word1 = w1;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (comp_q.size() != 0 || beat_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!bus_req && !done && !illegal, req, "quiet after command", {bus_req, done, illegal}, 0);
    if (legal && ld)
      for (int i = 0; i < n; i++)
        chk(regs[ra + 7'(i)] == exp_d[i], "R5", "loaded register", regs[ra + 7'(i)], exp_d[i]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) regs[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cmd_ready && !bus_req && !done && !illegal && !flush_req, "R11", "reset state",
        {cmd_ready, bus_req, done, illegal, flush_req}, 5'b10000);

    // R2 absolute store, memory space, flush requested (R10)
    base_addr = 32'h1000_0000; src_io = 1'b1; dst_io = 1'b0;
    issue(mk_w0(3'b111, 0, 0, 0, 7'd10, 3'd4), 32'h8000_0FFE, 32'h8000_0FFE, 1, 1, 0, "R2");

    // R3 relative store, negative offset, I/O space, no-flush set (R10)
    dst_io = 1'b1;
    issue(mk_w0(3'b111, 1, 1, 0, 7'd40, 3'd2), 32'h00FF_FFF0, 32'h0FFF_FFF0, 1, 0, 1, "R3");

    // R3 relative load, upper byte ignored, src I/O (R7), no-flush ignored for load (R10)
    base_addr = 32'h2000_0100; src_io = 1'b1; dst_io = 1'b0;
    issue(mk_w0(3'b111, 1, 1, 1, 7'd60, 3'd3), 32'hAB00_0040, 32'h2000_0140, 1, 0, 1, "R3");

    // R5 absolute load, one byte, memory space, flush bit clear still no flush (R10)
    src_io = 1'b0; dst_io = 1'b1;
    issue(mk_w0(3'b111, 0, 0, 1, 7'd100, 3'd1), 32'h0000_3300, 32'h0000_3300, 1, 0, 0, "R5");

    // R4 illegal counts
    issue(mk_w0(3'b111, 0, 0, 1, 7'd0, 3'd0), 32'h0000_1000, 0, 0, 0, 0, "R4");
    issue(mk_w0(3'b111, 0, 0, 0, 7'd0, 3'd5), 32'h0000_1000, 0, 0, 0, 0, "R4");
    issue(mk_w0(3'b111, 1, 0, 0, 7'd0, 3'd7), 32'h0000_1000, 0, 0, 0, 0, "R4");

    // R1 unrecognised opcode
    issue(mk_w0(3'b110, 0, 0, 0, 7'd5, 3'd2), 32'h0000_2000, 0, 0, 0, 0, "R1");

    // R6 store of bytes just loaded, with no-flush clear (R10)
    dst_io = 1'b0;
    issue(mk_w0(3'b111, 0, 0, 0, 7'd60, 3'd3), 32'h0000_5000, 32'h0000_5000, 1, 1, 0, "R6");

    chk(beat_q.size() == 0 && comp_q.size() == 0, "R9", "scoreboard drained",
        beat_q.size() + comp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule